// File: doc/BRIEF.md
# Multiprocessor Serial Port with Address Filtering

This block is an asynchronous serial port that a host reaches through a small register window. One location serves both directions: a read returns the most recently received byte, and a write hands a byte to the transmitter. A control register picks 8-bit or 9-bit frames, enables the receiver, turns on the multiprocessor filter and holds the ninth bit to send. A status register carries the transmit-done flag (TI), the receive-done flag (RI), the received ninth bit, a framing error flag and an overrun flag. A single-cycle `tick16` input runs at sixteen times the bit rate. Each bit lasts 16 ticks on both sides.

The receiver shifts a frame into an internal register and then copies it into a holding register. A second frame can therefore arrive while software has not yet read the first one. In multiprocessor mode, a 9-bit frame whose ninth bit is 1 is an address frame. It is compared with a slave address, but only in the bit positions that a mask register enables. A frame of nine ones always matches. Data frames are accepted only after a matching address has been received. The `irq` output is high while either TI or RI is set.

The transmitter state machine uses the states TX_IDLE, TX_START, TX_DATA, TX_NINTH and TX_STOP. It moves from TX_IDLE to TX_START on a data write. At each bit end it moves from TX_START to TX_DATA. After the eighth data bit it goes to TX_NINTH in 9-bit mode and to TX_STOP otherwise, and from TX_NINTH it goes to TX_STOP. At the end of the stop bit it returns to TX_IDLE and TI is set.

The receiver state machine uses the states RX_IDLE, RX_START, RX_DATA, RX_NINTH and RX_STOP. It moves from RX_IDLE to RX_START on a falling edge of the line. It moves from RX_START back to RX_IDLE when the vote at mid-bit is high, which rejects a glitch, and to RX_DATA at the end of the bit. After the eighth data bit it goes to RX_NINTH or RX_STOP, and from RX_NINTH it goes to RX_STOP. It moves from RX_STOP to RX_IDLE at the mid-bit vote, and it completes the frame there. Clearing the receive enable returns it to RX_IDLE from any state.

Top module: `mpu_uart`

## Requirements
- R1: After reset, the control, status, data, slave address and mask registers read 0, `tx_o` is 1 and `irq` is 0. The registers are at these addresses: data 0, control 1, status 2, slave address 3, mask 4.
- R2: A write to address 0 while the transmitter is idle sends a frame. The frame is a low start bit, then the 8 data bits LSB first, then (when control bit 3 is 1) a ninth bit taken from control bit 0, then a high stop bit. Each bit lasts 16 ticks, and the line rests high.
- R3: A write to address 0 while a frame is still being sent is ignored: the frame in progress is unchanged and no extra frame follows.
- R4: TI (status bit 1) is set when the stop bit of a sent frame ends. TI and RI (status bit 0) stay set until software writes 0 to that bit of the status register. Writing 1 to a flag bit leaves it unchanged.
- R5: When receive enable (control bit 1) is 1, an accepted frame is copied into the holding register, which is read at address 0, and RI is set. Status bit 2 takes the received ninth bit in 9-bit mode and the stop bit level in 8-bit mode.
- R6: When receive enable is 0, incoming frames change neither RI nor the holding register.
- R7: Each bit is the majority of three samples taken on ticks 7, 8 and 9 after the start edge. A start bit that votes high is dropped as a glitch, and the receiver then waits for the next falling edge.
- R8: The framing error flag (status bit 3) is set when an accepted frame has a stop bit that votes low. It is cleared by writing 0 to that bit.
- R9: If a frame is accepted while the previous byte has not yet been read at address 0, the overrun flag (status bit 4) is set and the holding register takes the newer byte.
- R10: In multiprocessor mode (control bits 2 and 3 both 1), a frame with ninth bit 1 is accepted only if it equals the slave address in every bit position where the mask is 1.
- R11: In multiprocessor mode, an address frame of 0xFF with ninth bit 1 is accepted whatever the slave address and mask hold.
- R12: In multiprocessor mode, a frame with ninth bit 0 is accepted only while the most recent address frame matched. No address has matched since reset.
- R13: `irq` is 1 exactly while TI or RI is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| bus_sel | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (the data read marks the byte as taken) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address on `bus_sel` |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq | output | 1 | High while TI or RI is set |

## Verification
The bench writes a second byte while the first is still shifting out. A transmitter that reloaded at that point would corrupt the frame on the line or add a frame that the scoreboard does not expect. It sends a frame that is never read and then a second one. A design with no double buffer or overrun logic would keep the old byte or leave the overrun flag clear. For the address filter, it sends an address that differs from the slave address only in a masked-off bit, an address that differs in an enabled bit, the all-ones broadcast, and data frames both before and after a match. A filter that ignored the mask, missed the broadcast or forgot the match state would raise RI on the wrong frames. It also sends a short low pulse, a frame with a low stop bit, and a frame while the receiver is disabled. These catch a receiver that starts on any edge, drops the framing error, or listens while it is off.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam logic [2:0] ADR_DATA = 3'd0;
    localparam logic [2:0] ADR_CTRL = 3'd1;
    localparam logic [2:0] ADR_STAT = 3'd2;
    localparam logic [2:0] ADR_SADR = 3'd3;
    localparam logic [2:0] ADR_SMSK = 3'd4;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP
    } rx_state_e;
endpackage

// File: rtl/mpu_tx.sv
module mpu_tx
    import mpu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_b9,
    input  logic          nine,
    output logic          tx_o,
    output logic          busy,
    output logic          done
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW);

    tx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q;
    logic          b9_q, nine_q;
    logic          bit_end;

    assign bit_end = tick && (cnt_q == CW'(OSR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && bit_q == BW'(DW - 1))
                          state_d = nine_q ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bit_end) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            b9_q   <= 1'b0;
            nine_q <= 1'b0;
        end else if (state_q == TX_IDLE) begin
            cnt_q <= '0;
            bit_q <= '0;
            if (load) begin
                sh_q   <= ld_data;
                b9_q   <= ld_b9;
                nine_q <= nine;
            end
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (bit_end && state_q == TX_DATA) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START: tx_o = 1'b0;
            TX_DATA:  tx_o = sh_q[0];
            TX_NINTH: tx_o = b9_q;
            default:  tx_o = 1'b1;
        endcase
        busy = (state_q != TX_IDLE);
        done = (state_q == TX_STOP) && bit_end;
    end
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
    import mpu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          nine,
    input  logic          rx_i,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          b9,
    output logic          stop_ok
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DW);
    localparam int MID = OSR / 2;

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q;
    logic          b9_q, nine_q;
    logic [1:0]    smp_q;
    logic [2:0]    sync_q;
    logic          fall, vote, mid_tick, bit_end;

    assign fall     = sync_q[2] & ~sync_q[1];
    assign vote     = (smp_q[0] & smp_q[1]) | (smp_q[0] & sync_q[1]) | (smp_q[1] & sync_q[1]);
    assign mid_tick = tick && (cnt_q == CW'(MID + 1));
    assign bit_end  = tick && (cnt_q == CW'(OSR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:  if (fall) state_d = RX_START;
                RX_START: if (mid_tick && vote) state_d = RX_IDLE;
                          else if (bit_end) state_d = RX_DATA;
                RX_DATA:  if (bit_end && bit_q == BW'(DW - 1))
                              state_d = nine_q ? RX_NINTH : RX_STOP;
                RX_NINTH: if (bit_end) state_d = RX_STOP;
                RX_STOP:  if (mid_tick) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            b9_q   <= 1'b0;
            nine_q <= 1'b0;
            smp_q  <= '1;
        end else begin
            sync_q <= {sync_q[1:0], rx_i};
            if (state_q == RX_IDLE) begin
                cnt_q  <= '0;
                bit_q  <= '0;
                nine_q <= nine;
            end else if (tick) begin
                cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
                if (cnt_q == CW'(MID - 1)) smp_q[0] <= sync_q[1];
                if (cnt_q == CW'(MID))     smp_q[1] <= sync_q[1];
                if (mid_tick && state_q == RX_DATA)  sh_q <= {vote, sh_q[DW-1:1]};
                if (mid_tick && state_q == RX_NINTH) b9_q <= vote;
                if (bit_end && state_q == RX_DATA)   bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        done    = en && (state_q == RX_STOP) && mid_tick;
        data    = sh_q;
        b9      = nine_q ? b9_q : vote;
        stop_ok = vote;
    end
endmodule

// File: rtl/mpu_match.sv
module mpu_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          b9,
    input  logic [DW-1:0] saddr,
    input  logic [DW-1:0] smask,
    output logic          match
);
    logic masked_eq, broadcast;

    always_comb begin
        masked_eq = (((data ^ saddr) & smask) == '0);
        broadcast = b9 && (data == '1);
        match     = masked_eq || broadcast;
    end
endmodule

// File: rtl/mpu_uart.sv
module mpu_uart
    import mpu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic [2:0]    bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_i,
    output logic          tx_o,
    output logic          irq
);
    logic          tb9_q, ren_q, mp_q, nine_q;
    logic          ri_q, ti_q, rb9_q, fe_q, ovr_q, full_q, addressed_q;
    logic [DW-1:0] hold_q, saddr_q, smask_q;
    logic          tx_busy, tx_done;
    logic          rx_done, rx_b9, rx_stop, addr_match, accept;
    logic [DW-1:0] rx_data;
    logic          stat_wr, data_rd, tx_load;

    assign stat_wr = bus_wr && (bus_sel == ADR_STAT);
    assign data_rd = bus_rd && (bus_sel == ADR_DATA);
    assign tx_load = bus_wr && (bus_sel == ADR_DATA);

    mpu_tx #(.DW(DW), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .load(tx_load),
        .ld_data(bus_wdata), .ld_b9(tb9_q), .nine(nine_q),
        .tx_o(tx_o), .busy(tx_busy), .done(tx_done)
    );

    mpu_rx #(.DW(DW), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .en(ren_q), .nine(nine_q),
        .rx_i(rx_i), .done(rx_done), .data(rx_data), .b9(rx_b9), .stop_ok(rx_stop)
    );

    mpu_match #(.DW(DW)) u_match (
        .data(rx_data), .b9(rx_b9), .saddr(saddr_q), .smask(smask_q), .match(addr_match)
    );

    always_comb begin
        if (nine_q && mp_q) accept = rx_done && (rx_b9 ? addr_match : addressed_q);
        else                accept = rx_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {nine_q, mp_q, ren_q, tb9_q} <= '0;
            saddr_q     <= '0;
            smask_q     <= '0;
            addressed_q <= 1'b0;
        end else begin
            if (bus_wr && bus_sel == ADR_CTRL) begin
                {nine_q, mp_q, ren_q, tb9_q} <= bus_wdata[3:0];
                if (!bus_wdata[2]) addressed_q <= 1'b0;
            end else if (rx_done && nine_q && mp_q && rx_b9) begin
                addressed_q <= addr_match;
            end
            if (bus_wr && bus_sel == ADR_SADR) saddr_q <= bus_wdata;
            if (bus_wr && bus_sel == ADR_SMSK) smask_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ri_q   <= 1'b0;
            ti_q   <= 1'b0;
            fe_q   <= 1'b0;
            ovr_q  <= 1'b0;
            full_q <= 1'b0;
            rb9_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            ti_q   <= tx_done | (ti_q & ~(stat_wr & ~bus_wdata[1]));
            ri_q   <= accept | (ri_q & ~(stat_wr & ~bus_wdata[0]));
            fe_q   <= (accept & ~rx_stop) | (fe_q & ~(stat_wr & ~bus_wdata[3]));
            ovr_q  <= (accept & full_q) | (ovr_q & ~(stat_wr & ~bus_wdata[4]));
            full_q <= accept | (full_q & ~data_rd);
            if (accept) begin
                hold_q <= rx_data;
                rb9_q  <= rx_b9;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_sel)
            ADR_DATA: bus_rdata = hold_q;
            ADR_CTRL: bus_rdata[3:0] = {nine_q, mp_q, ren_q, tb9_q};
            ADR_STAT: bus_rdata[4:0] = {ovr_q, fe_q, rb9_q, ti_q, ri_q};
            ADR_SADR: bus_rdata = saddr_q;
            ADR_SMSK: bus_rdata = smask_q;
            default:  bus_rdata = '0;
        endcase
        irq = ti_q | ri_q;
    end
endmodule

// File: rtl/mpu_uart_chk.sv
module mpu_uart_chk
    import mpu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_o,
    input logic          tx_busy,
    input logic          ri,
    input logic          ti,
    input logic          ovr,
    input logic          full,
    input logic          rx_done,
    input logic          nine,
    input logic          mp,
    input logic          rx_b9,
    input logic          match,
    input logic [DW-1:0] hold,
    input logic          bus_wr,
    input logic [2:0]    bus_sel,
    input logic [DW-1:0] bus_wdata
);
    logic stat_wr;
    assign stat_wr = bus_wr && (bus_sel == ADR_STAT);

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_o); // R2
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !tx_o); // R2
    AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ti && !(stat_wr && !bus_wdata[1]) |=> ti); // R4
    AST_RI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ri && !(stat_wr && !bus_wdata[0]) |=> ri); // R4
    AST_RI_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri) |-> $past(rx_done)); // R5
    AST_OVR_NEEDS_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full)); // R9
    AST_ADDR_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && nine && mp && rx_b9 && !match) |=> $stable(hold)); // R10
endmodule

bind mpu_uart mpu_uart_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .tx_busy(tx_busy),
    .ri(ri_q), .ti(ti_q), .ovr(ovr_q), .full(full_q),
    .rx_done(rx_done), .nine(nine_q), .mp(mp_q), .rx_b9(rx_b9),
    .match(addr_match), .hold(hold_q),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata)
);

// File: tb/mpu_uart_test.sv
module mpu_uart_test;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] tcnt = '0;
    logic [2:0] bus_sel = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_i = 1'b1;
    logic       tx_o, irq;

    int  nchk = 0, nerr = 0, nframes = 0;
    bit  mon_nine = 1'b0;
    bit  finished = 1'b0;
    logic [8:0] exp_q[$];

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tcnt   <= tcnt + 1'b1;
        tick16 <= (tcnt == 2'd3);
    end

    mpu_uart uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_i(rx_i), .tx_o(tx_o), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit b9, input bit nine, input bit stopv);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (nine) begin
            rx_i = b9;
            repeat (BITCLK) @(negedge clk);
        end
        rx_i = stopv;
        repeat (BITCLK) @(negedge clk);
        rx_i = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic wait_ti();
        logic [7:0] s;
        for (int i = 0; i < 200; i++) begin
            bus_read(3'd2, s);
            if (s[1]) break;
            repeat (14) @(negedge clk);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input bit b9);
        exp_q.push_back({b9, d});
        bus_write(3'd0, d);
    endtask

    // scoreboard monitor on the transmit line
    initial begin
        logic [8:0] got, exp;
        forever begin
            @(negedge clk);
            if (rst_n && tx_o === 1'b0) begin
                got = '0;
                repeat (BITCLK / 2) @(negedge clk);
                check("R2 start bit", tx_o, 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITCLK) @(negedge clk);
                    got[i] = tx_o;
                end
                if (mon_nine) begin
                    repeat (BITCLK) @(negedge clk);
                    got[8] = tx_o;
                end
                repeat (BITCLK) @(negedge clk);
                check("R2 stop bit", tx_o, 1'b1);
                nframes++;
                if (exp_q.size() == 0) begin
                    check("R3 unexpected frame", got, 9'h1FF ^ got);
                end else begin
                    exp = exp_q.pop_front();
                    check("R2 frame", got, exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset values
        bus_read(3'd1, v); check("R1 ctrl", v, 8'h00);
        bus_read(3'd2, v); check("R1 stat", v, 8'h00);
        bus_read(3'd0, v); check("R1 data", v, 8'h00);
        bus_read(3'd3, v); check("R1 saddr", v, 8'h00);
        bus_read(3'd4, v); check("R1 smask", v, 8'h00);
        check("R1 tx idle", tx_o, 1'b1);
        check("R1 irq", irq, 1'b0);

        // R2 8-bit transmit, R4 TI, R13 irq
        send_byte(8'hA5, 1'b0);
        wait_ti();
        repeat (100) @(negedge clk);
        bus_read(3'd2, v); check("R4 TI set", v[1], 1'b1);
        check("R13 irq from TI", irq, 1'b1);
        bus_write(3'd2, 8'hFF);
        repeat (20) @(negedge clk);
        bus_read(3'd2, v); check("R4 TI kept on write 1", v[1], 1'b1);
        bus_write(3'd2, 8'hFD);
        bus_read(3'd2, v); check("R4 TI cleared", v[1], 1'b0);
        check("R13 irq low", irq, 1'b0);

        // R3 write while busy ignored
        send_byte(8'h3C, 1'b0);
        repeat (100) @(negedge clk);
        bus_write(3'd0, 8'h55);
        wait_ti();
        repeat (900) @(negedge clk);
        check("R3 frames sent", nframes, 2);
        check("R3 queue drained", exp_q.size(), 0);
        bus_write(3'd2, 8'hFD);

        // R2 9-bit transmit
        mon_nine = 1'b1;
        bus_write(3'd1, 8'h09);
        send_byte(8'h5A, 1'b1);
        wait_ti();
        repeat (100) @(negedge clk);
        bus_write(3'd2, 8'hFD);
        bus_write(3'd1, 8'h08);
        send_byte(8'hC3, 1'b0);
        wait_ti();
        repeat (100) @(negedge clk);
        bus_write(3'd2, 8'hFD);
        check("R2 9-bit frames", nframes, 4);
        mon_nine = 1'b0;

        // R5 8-bit receive
        bus_write(3'd1, 8'h02);
        send_frame(8'h96, 1'b0, 1'b0, 1'b1);
        bus_read(3'd2, v); check("R5 status ri+rb8", v, 8'h05);
        check("R13 irq from RI", irq, 1'b1);
        bus_read(3'd0, v); check("R5 data", v, 8'h96);
        bus_write(3'd2, 8'hFE);

        // R6 receiver off
        bus_write(3'd1, 8'h00);
        send_frame(8'h11, 1'b0, 1'b0, 1'b1);
        bus_read(3'd2, v); check("R6 no RI", v[0], 1'b0);
        bus_read(3'd0, v); check("R6 data kept", v, 8'h96);

        // R7 glitch rejection then a valid frame
        bus_write(3'd1, 8'h02);
        @(negedge clk); rx_i = 1'b0;
        repeat (8) @(negedge clk); rx_i = 1'b1;
        repeat (1500) @(negedge clk);
        bus_read(3'd2, v); check("R7 glitch ignored", v[0], 1'b0);
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        bus_read(3'd0, v); check("R7 frame after glitch", v, 8'h3C);
        bus_write(3'd2, 8'hFE);

        // R8 framing error
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
        bus_read(3'd2, v); check("R8 fe set", v[3], 1'b1);
        bus_read(3'd0, v); check("R8 data", v, 8'h5A);
        bus_write(3'd2, 8'hF6);
        bus_read(3'd2, v); check("R8 fe cleared", v[3], 1'b0);

        // R9 overrun
        send_frame(8'h01, 1'b0, 1'b0, 1'b1);
        send_frame(8'h02, 1'b0, 1'b0, 1'b1);
        bus_read(3'd2, v); check("R9 overrun", v[4], 1'b1);
        bus_read(3'd0, v); check("R9 newer byte", v, 8'h02);
        bus_write(3'd2, 8'hEE);

        // R5 9-bit receive
        bus_write(3'd1, 8'h0A);
        send_frame(8'h33, 1'b0, 1'b1, 1'b1);
        bus_read(3'd2, v); check("R5 rb8 zero", v[2], 1'b0);
        bus_read(3'd0, v); check("R5 9-bit data", v, 8'h33);
        bus_write(3'd2, 8'hFE);
        send_frame(8'h44, 1'b1, 1'b1, 1'b1);
        bus_read(3'd2, v); check("R5 rb8 one", v[2], 1'b1);
        bus_read(3'd0, v);
        bus_write(3'd2, 8'hFE);

        // R10 R11 R12 multiprocessor filtering
        bus_write(3'd3, 8'h35);
        bus_write(3'd4, 8'h0F);
        bus_write(3'd1, 8'h0E);
        send_frame(8'h77, 1'b0, 1'b1, 1'b1);
        bus_read(3'd2, v); check("R12 data before address", v[0], 1'b0);
        send_frame(8'h45, 1'b1, 1'b1, 1'b1);
        bus_read(3'd2, v); check("R10 masked match RI", v[0], 1'b1);
        bus_read(3'd0, v); check("R10 address byte", v, 8'h45);
        bus_write(3'd2, 8'hFE);
        send_frame(8'h66, 1'b0, 1'b1, 1'b1);
        bus_read(3'd2, v); check("R12 data after match", v[0], 1'b1);
        bus_read(3'd0, v); check("R12 data byte", v, 8'h66);
        bus_write(3'd2, 8'hFE);
        send_frame(8'h46, 1'b1, 1'b1, 1'b1);
        bus_read(3'd2, v); check("R10 mismatch no RI", v[0], 1'b0);
        send_frame(8'h99, 1'b0, 1'b1, 1'b1);
        bus_read(3'd2, v); check("R12 data after mismatch", v[0], 1'b0);
        bus_read(3'd0, v); check("R12 holding kept", v, 8'h66);
        send_frame(8'hFF, 1'b1, 1'b1, 1'b1);
        bus_read(3'd2, v); check("R11 broadcast RI", v[0], 1'b1);
        bus_read(3'd0, v); check("R11 broadcast byte", v, 8'hFF);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule